// File: doc/BRIEF.md
# Nine-bit multiprocessor serial port

A full-duplex asynchronous serial port controlled through a byte-wide register bus. Software picks a frame format in a control register, writes a byte to the data address to send it, and reads received bytes from the same address. An external baud tick paces both directions. Each bit lasts sixteen ticks. The receiver finds a start bit on a falling edge and samples every bit at its middle.

A second format adds a ninth bit to each frame. On transmit this bit comes from a control bit. On receive it is captured into a status bit. With the address-filter option on, a nine-bit frame whose ninth bit is 0 is dropped silently. A node on a shared line therefore wakes only for address frames. The transmit-done and receive-done flags ignore written ones. Software clears one flag by writing a full byte whose only zero is at that flag, so it never races the hardware. One interrupt line reports either flag.

Top module: `mpser_port`

## Requirements
- R1: Control bits [1:0] select the frame format. 00 is off: a data write sends nothing and nothing is received. 01 gives 8-bit frames. 10 and 11 give 9-bit frames.
- R2: A write to address 1 starts a frame on `ser_tx`. The frame is a start bit 0, then data bits LSB first, then in 9-bit formats control bit 4, then a stop bit 1. Each bit lasts 16 baud ticks. The line idles high, and a data write while a frame is in progress is ignored.
- R3: Control bit 2 enables reception. While it is 0, incoming frames change neither the receive buffer nor any flag.
- R4: A received byte is read at address 1. In 9-bit formats, control bit 5 takes the ninth received bit. In the 8-bit format with bit 3 clear, bit 5 takes the received stop bit.
- R5: With control bit 3 set in a 9-bit format, a frame whose ninth bit is 0 leaves the buffer and the receive flag untouched. A frame whose ninth bit is 1 is accepted.
- R6: Control bit 7 (transmit done) and bit 6 (receive done) are set only by frame completion. Writing 0 to one of them clears it, and writing 1 leaves it unchanged. All other control bits are plain read/write.
- R7: When frame completion and a write of 0 to the same flag fall in one cycle, the flag ends set.
- R8: A start bit that reads high at its mid-point is dropped, and the receiver goes back to waiting for a falling edge.
- R9: `irq` is high exactly when bit 6 or bit 7 is set.
- R10: After reset the control register reads 0, `ser_tx` is high and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects control, 1 selects data |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| ser_rx | input | 1 | Serial receive line |
| ser_tx | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt, OR of both done flags |

## Verification
The bench times a flag-clear write to land in the exact cycle of transmit completion. A design that let the write win would lose the completion event. Nine-bit frames are sent with a zero ninth bit while the filter is on; a design that filtered too little would overwrite the buffer, and one that filtered in the wrong format would drop real data. The bench also sends a short low glitch and a framing error with a zero stop bit. A naive receiver would turn the glitch into a frame, or would report the wrong captured stop bit. Writes made during a transmission are compared bit by bit against a behavioural line model, which catches a design that restarts its frame.

// File: rtl/mpser_pkg.sv
package mpser_pkg;

   typedef enum logic [1:0] {
      MODE_OFF    = 2'b00,
      MODE_BYTE   = 2'b01,
      MODE_NINE_A = 2'b10,
      MODE_NINE_B = 2'b11
   } frame_mode_e;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_BITS
   } rx_state_e;

   // control register bit positions
   localparam int unsigned CB_MODE = 0;
   localparam int unsigned CB_RXEN = 2;
   localparam int unsigned CB_MPEN = 3;
   localparam int unsigned CB_TX9  = 4;
   localparam int unsigned CB_RX9  = 5;
   localparam int unsigned CB_RXF  = 6;
   localparam int unsigned CB_TXF  = 7;

   localparam int unsigned NUM_FLAGS = 2;

endpackage

// File: rtl/mpser_tx.sv
module mpser_tx #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic              nine,
   input  logic              bit9,
   input  logic [DATA_W-1:0] data,
   output logic              txd,
   output logic              fin
);
   localparam int unsigned CNT_W  = $clog2(OVS);
   localparam int unsigned LEFT_W = $clog2(DATA_W + 3);
   localparam logic [CNT_W-1:0]  CNT_LAST   = CNT_W'(OVS - 1);
   localparam logic [LEFT_W-1:0] LEFT_BYTE  = LEFT_W'(DATA_W + 1);
   localparam logic [LEFT_W-1:0] LEFT_NINE  = LEFT_W'(DATA_W + 2);

   logic [CNT_W-1:0]  cnt;
   logic [LEFT_W-1:0] left;
   logic [DATA_W:0]   sh;
   logic              busy_q;
   logic              txd_q;
   logic              load;
   logic              bit_end;

   assign load    = start & ~busy_q;
   assign bit_end = busy_q & tick & (cnt == CNT_LAST);
   assign fin     = bit_end & (left == '0);
   assign txd     = txd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         txd_q  <= 1'b1;
         cnt    <= '0;
         left   <= '0;
         sh     <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         txd_q  <= 1'b0;
         cnt    <= '0;
         sh     <= {(nine ? bit9 : 1'b1), data};
         left   <= nine ? LEFT_NINE : LEFT_BYTE;
      end else if (busy_q && tick) begin
         if (cnt == CNT_LAST) begin
            cnt <= '0;
            if (left == '0) begin
               busy_q <= 1'b0;
            end else begin
               txd_q <= sh[0];
               sh    <= {1'b1, sh[DATA_W:1]};
               left  <= left - 1'b1;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   a_r2_idle_high : assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> txd_q);

   a_r2_bit_hold : assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !bit_end |=> $stable(txd_q));

   a_r2_no_restart : assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && start && !bit_end |=> $stable(sh) && $stable(left));

   a_r2_frame_end : assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !busy_q && txd_q);

endmodule

// File: rtl/mpser_rx.sv
module mpser_rx
   import mpser_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            en,
   input  logic            nine,
   input  logic            rxd,
   output logic            fin,
   output logic [DATA_W:0] word
);
   localparam int unsigned CNT_W = $clog2(OVS);
   localparam int unsigned IDX_W = $clog2(DATA_W + 2);
   localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OVS - 1);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
   localparam logic [IDX_W-1:0] IDX_BYTE  = IDX_W'(DATA_W);
   localparam logic [IDX_W-1:0] IDX_NINE  = IDX_W'(DATA_W + 1);

   rx_state_e              state;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur;
   logic [CNT_W-1:0]       cnt;
   logic [IDX_W-1:0]       idx;
   logic [IDX_W-1:0]       idx_last;
   logic [DATA_W:0]        sh;
   logic                   samp;
   logic                   store;

   assign cur      = sync_q[SYNC_STAGES-1];
   assign idx_last = nine ? IDX_NINE : IDX_BYTE;
   assign store    = (idx <= IDX_BYTE);
   assign samp     = (state == RX_BITS) & tick & (cnt == CNT_LAST);
   assign fin      = samp & (idx == idx_last) & en;
   assign word     = (samp & store) ? {cur, sh[DATA_W:1]} : sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
         state  <= RX_IDLE;
         cnt    <= '0;
         idx    <= '0;
         sh     <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
         prev_q <= cur;
         if (!en) begin
            state <= RX_IDLE;
         end else begin
            case (state)
               RX_IDLE: begin
                  if (prev_q && !cur) begin
                     state <= RX_START;
                     cnt   <= '0;
                  end
               end
               RX_START: begin
                  if (tick) begin
                     if (cnt == HALF_LAST) begin
                        cnt   <= '0;
                        idx   <= '0;
                        state <= cur ? RX_IDLE : RX_BITS;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               RX_BITS: begin
                  if (tick) begin
                     if (cnt == CNT_LAST) begin
                        cnt <= '0;
                        if (store) sh <= {cur, sh[DATA_W:1]};
                        if (idx == idx_last) state <= RX_IDLE;
                        else                 idx   <= idx + 1'b1;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   a_r3_disabled_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> state == RX_IDLE);

   a_r8_false_start : assert property (@(posedge clk) disable iff (!rst_n)
      en && state == RX_START && tick && cnt == HALF_LAST && cur |=> state == RX_IDLE);

   a_r8_bits_after_start : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == RX_BITS) |-> $past(state) == RX_START);

endmodule

// File: rtl/mpser_regs.sv
module mpser_regs
   import mpser_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output frame_mode_e       mode,
   output logic              rx_en,
   output logic              tx9,
   output logic              tx_start,
   input  logic              tx_fin,
   input  logic              rx_fin,
   input  logic [DATA_W:0]   rx_word,
   output logic              irq
);
   frame_mode_e          mode_q;
   logic                 rxen_q;
   logic                 mpen_q;
   logic                 tx9_q;
   logic                 rx9_q;
   logic [DATA_W-1:0]    buf_q;
   logic [NUM_FLAGS-1:0] flags;
   logic [NUM_FLAGS-1:0] set_ev;
   logic                 ctrl_wr;
   logic                 nine;
   logic                 accept;
   logic [DATA_W-1:0]    ctrl_img;

   assign ctrl_wr  = wr & ~addr;
   assign tx_start = wr & addr & (mode_q != MODE_OFF);
   assign nine     = mode_q[1];
   assign accept   = rx_fin & (~(nine & mpen_q) | rx_word[DATA_W]);
   assign set_ev   = {tx_fin, accept};

   // flag index 0 is receive done, 1 is transmit done
   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= set_ev[i] | (q & ~(ctrl_wr & ~wdata[CB_RXF + i]));
      end
      assign flags[i] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_OFF;
         rxen_q <= 1'b0;
         mpen_q <= 1'b0;
         tx9_q  <= 1'b0;
         rx9_q  <= 1'b0;
         buf_q  <= '0;
      end else begin
         if (ctrl_wr) begin
            mode_q <= frame_mode_e'(wdata[CB_MODE +: 2]);
            rxen_q <= wdata[CB_RXEN];
            mpen_q <= wdata[CB_MPEN];
            tx9_q  <= wdata[CB_TX9];
            rx9_q  <= wdata[CB_RX9];
         end
         if (accept) begin
            buf_q <= rx_word[DATA_W-1:0];
            if (nine || !mpen_q) rx9_q <= rx_word[DATA_W];
         end
      end
   end

   always_comb begin
      ctrl_img                = '0;
      ctrl_img[CB_MODE +: 2]  = mode_q;
      ctrl_img[CB_RXEN]       = rxen_q;
      ctrl_img[CB_MPEN]       = mpen_q;
      ctrl_img[CB_TX9]        = tx9_q;
      ctrl_img[CB_RX9]        = rx9_q;
      ctrl_img[CB_RXF]        = flags[0];
      ctrl_img[CB_TXF]        = flags[1];
      rdata = addr ? buf_q : ctrl_img;
   end

   assign mode  = mode_q;
   assign rx_en = rxen_q;
   assign tx9   = tx9_q;
   assign irq   = |flags;

   a_r7_tx_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      tx_fin |=> flags[1]);

   a_r7_rx_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> flags[0]);

   a_r6_tx_clear_by_zero : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[1]) |-> $past(ctrl_wr && !wdata[CB_TXF]));

   a_r6_rx_clear_by_zero : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[0]) |-> $past(ctrl_wr && !wdata[CB_RXF]));

   a_r6_rx_set_by_frame : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> $past(rx_fin));

   a_r5_filter_keeps_buffer : assert property (@(posedge clk) disable iff (!rst_n)
      rx_fin && nine && mpen_q && !rx_word[DATA_W] |=> $stable(buf_q));

endmodule

// File: rtl/mpser_port.sv
module mpser_port
   import mpser_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              bus_wr,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ser_rx,
   output logic              ser_tx,
   output logic              irq
);
   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must hold the eight control bits");
   end
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   frame_mode_e     mode;
   logic            rx_en;
   logic            tx9;
   logic            tx_start;
   logic            tx_fin;
   logic            rx_fin;
   logic [DATA_W:0] rx_word;
   logic            port_on;

   assign port_on = (mode != MODE_OFF);

   mpser_regs #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .rdata    (bus_rdata),
      .mode     (mode),
      .rx_en    (rx_en),
      .tx9      (tx9),
      .tx_start (tx_start),
      .tx_fin   (tx_fin),
      .rx_fin   (rx_fin),
      .rx_word  (rx_word),
      .irq      (irq)
   );

   mpser_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (baud_tick),
      .start (tx_start),
      .nine  (mode[1]),
      .bit9  (tx9),
      .data  (bus_wdata),
      .txd   (ser_tx),
      .fin   (tx_fin)
   );

   mpser_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (baud_tick),
      .en    (rx_en & port_on),
      .nine  (mode[1]),
      .rxd   (ser_rx),
      .fin   (rx_fin),
      .word  (rx_word)
   );

   a_r9_irq_follows_flags : assert property (@(posedge clk) disable iff (!rst_n)
      irq == (bus_addr ? irq : (bus_rdata[CB_TXF] | bus_rdata[CB_RXF])));

   a_r1_off_sends_nothing : assert property (@(posedge clk) disable iff (!rst_n)
      !port_on && ser_tx |=> ser_tx);

endmodule

// File: tb/mpser_port_test.sv
module mpser_port_test;
   localparam int CLK_PERIOD = 10;
   localparam int BIT_CLKS   = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick;
   logic       bus_wr = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       ser_rx = 1'b1;
   logic       ser_tx;
   logic       irq;

   int total = 0;
   int bad   = 0;
   int ph    = 0;

   // behavioural line model for the transmitter and its done flag
   bit         q[$];
   bit         m_busy = 0;
   bit         m_txd  = 1;
   bit         m_txf  = 0;
   int         m_cnt  = 0;
   logic [1:0] m_mode = 2'b00;
   bit         m_tx9  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign baud_tick = (ph == 3);

   mpser_port uut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .ser_rx(ser_rx), .ser_tx(ser_tx), .irq(irq)
   );

   always @(posedge clk) begin
      bit fin;
      fin = 0;
      ph <= (ph + 1) % 4;
      if (!rst_n) begin
         m_busy = 0; m_txd = 1; m_txf = 0; m_cnt = 0; m_mode = 2'b00; m_tx9 = 0;
         q.delete();
      end else begin
         if (bus_wr && bus_addr && m_mode != 2'b00 && !m_busy) begin
            m_busy = 1; m_txd = 0; m_cnt = 0;
            q.delete();
            for (int i = 0; i < 8; i++) q.push_back(bus_wdata[i]);
            if (m_mode[1]) q.push_back(m_tx9);
            q.push_back(1'b1);
         end else if (m_busy && baud_tick) begin
            if (m_cnt == 15) begin
               m_cnt = 0;
               if (q.size() == 0) begin
                  m_busy = 0;
                  fin = 1;
               end else begin
                  m_txd = q.pop_front();
               end
            end else begin
               m_cnt++;
            end
         end
         m_txf = fin | (m_txf & !(bus_wr && !bus_addr && !bus_wdata[7]));
         if (bus_wr && !bus_addr) begin
            m_mode = bus_wdata[1:0];
            m_tx9  = bus_wdata[4];
         end
      end
   end

   // per-clock comparison, away from both edges
   always @(posedge clk) begin
      #3;
      if (rst_n) begin
         total++;
         if (ser_tx !== m_txd || (bus_addr == 1'b0 && bus_rdata[7] !== m_txf)) begin
            bad++;
            $display("FAIL R2/R6 line model: tx=%0b exp=%0b txflag=%0b exp=%0b at %0t",
                     ser_tx, m_txd, bus_rdata[7], m_txf, $time);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
      bus_addr = 1'b0;
   endtask

   task automatic send(input logic [7:0] d, input bit has9, input bit b9, input bit stp);
      @(negedge clk);
      ser_rx = 1'b0;
      repeat (BIT_CLKS) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         ser_rx = d[i];
         repeat (BIT_CLKS) @(negedge clk);
      end
      if (has9) begin
         ser_rx = b9;
         repeat (BIT_CLKS) @(negedge clk);
      end
      ser_rx = stp;
      repeat (BIT_CLKS) @(negedge clk);
      ser_rx = 1'b1;
      repeat (40) @(negedge clk);
   endtask

   task automatic wait_tx();
      do @(negedge clk); while (m_busy);
      repeat (2) @(negedge clk);
   endtask

   function automatic logic [7:0] cfg(input logic [1:0] m, input bit re, input bit mp, input bit t9);
      return {2'b11, 1'b0, t9, mp, re, m};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [7:0] c;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      rd(1'b0, v);
      chk(v == 8'h00, "R10 ctrl after reset", v, 0);
      chk(ser_tx == 1'b1, "R10 tx idle", ser_tx, 1);
      chk(irq == 1'b0, "R10 irq", irq, 0);

      // R6 writing ones to flags has no effect
      c = cfg(2'b01, 1, 0, 0);
      wr(1'b0, c);
      rd(1'b0, v);
      chk(v == (c & 8'h3F), "R6 ones written to clear flags", v, c & 8'h3F);

      // R2 8-bit transmit, R6 flag, R9 irq
      wr(1'b1, 8'hA5);
      wait_tx();
      rd(1'b0, v);
      chk(v[7] == 1'b1, "R6 tx done set", v[7], 1);
      chk(irq == 1'b1, "R9 irq on tx done", irq, 1);
      wr(1'b0, c & 8'h7F);
      rd(1'b0, v);
      chk(v[7] == 1'b0, "R6 tx done cleared by zero", v[7], 0);
      chk(irq == 1'b0, "R9 irq low", irq, 0);

      // R4 8-bit receive, stop bit captured
      send(8'h3C, 0, 0, 1);
      rd(1'b1, v);
      chk(v == 8'h3C, "R4 rx byte", v, 8'h3C);
      rd(1'b0, v);
      chk(v[6] == 1'b1, "R6 rx done set", v[6], 1);
      chk(v[5] == 1'b1, "R4 stop bit captured high", v[5], 1);
      chk(irq == 1'b1, "R9 irq on rx done", irq, 1);

      // R6 ones keep a set flag
      wr(1'b0, c);
      rd(1'b0, v);
      chk(v[6] == 1'b1, "R6 one written keeps rx flag", v[6], 1);
      wr(1'b0, c & 8'hBF);
      rd(1'b0, v);
      chk(v[6] == 1'b0, "R6 rx done cleared by zero", v[6], 0);

      // R4 zero stop bit captured
      send(8'hC3, 0, 0, 0);
      rd(1'b1, v);
      chk(v == 8'hC3, "R4 rx byte framing error", v, 8'hC3);
      rd(1'b0, v);
      chk(v[5] == 1'b0, "R4 stop bit captured low", v[5], 0);

      // R2 9-bit transmit, ninth bit 1 then 0, write while busy ignored
      c = cfg(2'b10, 1, 0, 1);
      wr(1'b0, c & 8'h3F);
      wr(1'b1, 8'h96);
      repeat (100) @(negedge clk);
      wr(1'b1, 8'hFF);
      wait_tx();
      c = cfg(2'b10, 1, 0, 0);
      wr(1'b0, c & 8'h3F);
      wr(1'b1, 8'h01);
      wait_tx();
      rd(1'b0, v);
      chk(v[7] == 1'b1, "R2 nine-bit frame completes", v[7], 1);

      // R5 address filter in mode 11
      c = cfg(2'b11, 1, 1, 0);
      wr(1'b0, c & 8'h3F);
      send(8'h55, 1, 0, 1);
      rd(1'b1, v);
      chk(v == 8'hC3, "R5 data frame leaves buffer", v, 8'hC3);
      rd(1'b0, v);
      chk(v[6] == 1'b0, "R5 data frame sets no flag", v[6], 0);
      send(8'hAA, 1, 1, 1);
      rd(1'b1, v);
      chk(v == 8'hAA, "R5 address frame accepted", v, 8'hAA);
      rd(1'b0, v);
      chk(v[6] == 1'b1, "R5 address frame flag", v[6], 1);
      chk(v[5] == 1'b1, "R4 ninth bit captured high", v[5], 1);

      // R4 9-bit receive without filter, ninth bit 0
      c = cfg(2'b10, 1, 0, 0);
      wr(1'b0, c & 8'h3F);
      send(8'h12, 1, 0, 1);
      rd(1'b1, v);
      chk(v == 8'h12, "R4 nine-bit rx byte", v, 8'h12);
      rd(1'b0, v);
      chk(v[5] == 1'b0 && v[6] == 1'b1, "R4 ninth bit captured low", v[6:5], 2'b10);

      // R3 receive disabled
      c = cfg(2'b01, 0, 0, 0);
      wr(1'b0, c & 8'h3F);
      send(8'h77, 0, 0, 1);
      rd(1'b1, v);
      chk(v == 8'h12, "R3 disabled rx leaves buffer", v, 8'h12);
      rd(1'b0, v);
      chk(v[6] == 1'b0, "R3 disabled rx sets no flag", v[6], 0);

      // R8 false start then a real frame
      c = cfg(2'b01, 1, 0, 0);
      wr(1'b0, c & 8'h3F);
      @(negedge clk);
      ser_rx = 1'b0;
      repeat (8) @(negedge clk);
      ser_rx = 1'b1;
      repeat (200) @(negedge clk);
      rd(1'b0, v);
      chk(v[6] == 1'b0, "R8 glitch gives no frame", v[6], 0);
      send(8'h5E, 0, 0, 1);
      rd(1'b1, v);
      chk(v == 8'h5E, "R8 frame after glitch", v, 8'h5E);

      // R1 mode off: no transmit, no receive
      c = cfg(2'b00, 1, 0, 0);
      wr(1'b0, c & 8'h3F);
      wr(1'b1, 8'h33);
      repeat (100) @(negedge clk);
      chk(ser_tx == 1'b1, "R1 mode off sends nothing", ser_tx, 1);
      send(8'h44, 0, 0, 1);
      rd(1'b1, v);
      chk(v == 8'h5E, "R1 mode off receives nothing", v, 8'h5E);
      rd(1'b0, v);
      chk(v[7:6] == 2'b00, "R1 mode off sets no flag", v[7:6], 0);

      // R7 clear write in the completion cycle
      c = cfg(2'b01, 1, 0, 0);
      wr(1'b0, c & 8'h3F);
      wr(1'b1, 8'h5A);
      forever begin
         @(negedge clk);
         if (m_busy && m_cnt == 15 && q.size() == 0 && baud_tick) break;
      end
      bus_addr = 1'b0; bus_wdata = c & 8'h7F; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(1'b0, v);
      chk(v[7] == 1'b1, "R7 completion beats clear", v[7], 1);

      repeat (5) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule